// File: doc/BRIEF.md
# Reference Clock Failover Selector

This block chooses which of two reference clocks feeds the clock tree downstream, and it hands over from one clock to the other without a glitch. A control clock runs a small selection machine. The machine reads a 4-bit control word, a manual select line and one valid flag per input. Each valid flag is assumed to come from an external loss-of-clock detector that is synchronous to the control clock. The control word holds three fields: a priority bit that names the primary input, a reserved bit, and a 2-bit failover mode.

In the two manual encodings, the active input follows the manual select line. In the automatic modes, the block moves away from an input as soon as that input's valid flag drops. The holding variant then stays on the backup. The reverting variant returns to the primary once the primary has been valid for a programmable number of consecutive control cycles.

The selected clock passes through a two-branch gating stage. Each branch is enabled and disabled on the falling edge of its own clock, through a synchronizer chain. A branch may start only after the other branch's chain has fully drained.

Top module: `refclk_switch`

## Requirements
- R1: While reset is held, and on the first cycle after it, `active_src` equals the priority bit `ctrl_cfg[3]` and `no_valid` is 0.
- R2: With `ctrl_cfg[1:0]` equal to 00 or 01 (manual), `active_src` takes the value of `man_sel` one control cycle later, whatever `ref_valid` holds. In these modes `no_valid` is 0.
- R3: The priority bit `ctrl_cfg[3]` names the primary input (0 selects `clk_ref_a`, 1 selects `clk_ref_b`), and the reverting mode returns to that input.
- R4: With mode 10 (automatic, holding), the block moves to the other input one cycle after the active input's valid flag (`ref_valid[active_src]`) is seen low while the other flag is high. It never moves while the active input is valid.
- R5: With mode 11 (automatic, reverting), failover behaves as in R4. While on the backup, the block returns to the primary on the HOLD_CYCLES-th consecutive control edge at which the primary's valid flag is high. Any low sample restarts that count.
- R6: In either automatic mode, when both valid flags are low, `active_src` holds its value and `no_valid` is 1 on the next cycle. The flag clears one cycle after a valid input is seen again.
- R7: The reserved bit `ctrl_cfg[2]` has no effect on selection or status.
- R8: `clk_out` never produces a high or low phase shorter than the shorter half-period of the two inputs, and the two gate enables are never both high.
- R9: Once a handover has settled, `clk_out` carries the same number of rising edges as the input named by `active_src`, within one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the selection machine |
| rst | input | 1 | Synchronous active-high reset |
| clk_ref_a | input | 1 | Reference input 0 |
| clk_ref_b | input | 1 | Reference input 1 |
| ctrl_cfg | input | 4 | [3] priority, [2] reserved, [1:0] failover mode |
| man_sel | input | 1 | Input to use in manual mode (0 = a, 1 = b) |
| ref_valid | input | 2 | Per-input valid flags, bit 0 for a, bit 1 for b |
| clk_out | output | 1 | Glitch-free selected clock |
| active_src | output | 1 | Input currently chosen (0 = a, 1 = b) |
| no_valid | output | 1 | Both inputs invalid in an automatic mode |

## Verification
`active_src` and `no_valid` are registered once on the control clock. The bench therefore drives each stimulus on a falling control edge and samples exactly one rising edge later, on the following falling edge. The return to the primary in reverting mode is due on the HOLD_CYCLES-th rising edge. The bench samples one edge before that edge, to confirm no early switch, and then on it. The clock output lags a selection change by the drain of two synchronizer chains in the two input domains, about 50 ns with the bench clocks. Edge-count comparisons for `clk_out` therefore start only after a 240 ns settling wait. The pulse-width monitor runs over the whole test, across every handover.

// File: rtl/refclk_switch_pkg.sv
package refclk_switch_pkg;

    typedef enum logic [1:0] {
        SW_MANUAL_0   = 2'b00,
        SW_MANUAL_1   = 2'b01,
        SW_AUTO_HOLD  = 2'b10,
        SW_AUTO_BACK  = 2'b11
    } sw_mode_e;

    typedef struct packed {
        logic     prio;   // primary input index
        logic     rsvd;   // no function
        sw_mode_e mode;
    } sw_cfg_t;

    localparam int NUM_REFS = 2;

    function automatic logic mode_is_auto(input sw_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_returns(input sw_mode_e m);
        return m == SW_AUTO_BACK;
    endfunction

endpackage

// File: rtl/refclk_sw_select.sv
module refclk_sw_select
    import refclk_switch_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  sw_cfg_t       cfg,
    input  logic          man_sel,
    input  logic [NUM_REFS-1:0] valid,
    output logic          sel,
    output logic          none_ok
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    logic             sel_q, nv_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cur_ok, alt_ok, prim_ok, on_backup;
    logic             unused_rsvd;

    assign unused_rsvd = cfg.rsvd;
    assign cur_ok    = valid[sel_q];
    assign alt_ok    = valid[~sel_q];
    assign prim_ok   = valid[cfg.prio];
    assign on_backup = (sel_q != cfg.prio);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= cfg.prio;
            nv_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!mode_is_auto(cfg.mode)) begin
            sel_q <= man_sel;
            nv_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            nv_q <= ~|valid;
            if (!cur_ok && alt_ok) begin
                sel_q <= ~sel_q;
                cnt_q <= '0;
            end else if (mode_returns(cfg.mode) && on_backup && prim_ok) begin
                if (cnt_q == CNT_LAST) begin
                    sel_q <= cfg.prio;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign sel     = sel_q;
    assign none_ok = nv_q;

endmodule

// File: rtl/refclk_sw_gate.sv
module refclk_sw_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst,
    input  logic want,
    input  logic peer_busy,
    output logic en,
    output logic busy
);
    logic [SYNC_STAGES-1:0] chain_q;

    // Updates on the falling edge so the gate only moves while the clock is low.
    always_ff @(negedge clk_src) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], want & ~peer_busy};
    end

    assign en   = chain_q[SYNC_STAGES-1];
    assign busy = |chain_q;

endmodule

// File: rtl/refclk_switch.sv
module refclk_switch
    import refclk_switch_pkg::*;
#(
    parameter int HOLD_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_ref_a,
    input  logic       clk_ref_b,
    input  logic [3:0] ctrl_cfg,
    input  logic       man_sel,
    input  logic [1:0] ref_valid,
    output logic       clk_out,
    output logic       active_src,
    output logic       no_valid
);
    sw_cfg_t             cfg;
    logic                sel;
    logic [NUM_REFS-1:0] src_clk, gate_en, gate_busy;

    assign cfg     = sw_cfg_t'(ctrl_cfg);
    assign src_clk = {clk_ref_b, clk_ref_a};

    refclk_sw_select #(.HOLD_CYCLES(HOLD_CYCLES)) u_select (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .man_sel (man_sel),
        .valid   (ref_valid),
        .sel     (sel),
        .none_ok (no_valid)
    );

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_branch
        localparam logic IDX = 1'(i);
        refclk_sw_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_src   (src_clk[i]),
            .rst       (rst),
            .want      (sel == IDX),
            .peer_busy (gate_busy[NUM_REFS-1-i]),
            .en        (gate_en[i]),
            .busy      (gate_busy[i])
        );
    end

    assign clk_out    = |(src_clk & gate_en);
    assign active_src = sel;

endmodule

// File: rtl/refclk_switch_chk.sv
module refclk_switch_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] ctrl_cfg,
    input logic       man_sel,
    input logic [1:0] ref_valid,
    input logic       active_src,
    input logic       no_valid,
    input logic [1:0] en_vec
);
    logic cur_valid;
    assign cur_valid = active_src ? ref_valid[1] : ref_valid[0];

    assert_manual_follow_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_cfg[1] |=> (active_src == $past(man_sel)) && !no_valid);

    assert_hold_while_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_cfg[1:0] == 2'b10 && cur_valid) |=> $stable(active_src));

    assert_none_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_cfg[1] && ref_valid == 2'b00) |=> no_valid);

    assert_none_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_cfg[1] && ref_valid == 2'b00) |=> $stable(active_src));

    assert_gate_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(en_vec[0] && en_vec[1]));

endmodule

bind refclk_switch refclk_switch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_cfg   (ctrl_cfg),
    .man_sel    (man_sel),
    .ref_valid  (ref_valid),
    .active_src (active_src),
    .no_valid   (no_valid),
    .en_vec     (gate_en)
);

// File: tb/refclk_switch_tb.sv
`timescale 1ns/1ps
module refclk_switch_tb;
    localparam int HOLD = 16;

    logic       clk = 1'b0, rst = 1'b1;
    logic       clk_ref_a = 1'b0, clk_ref_b = 1'b0;
    logic [3:0] ctrl_cfg = 4'b0011;
    logic       man_sel = 1'b0;
    logic [1:0] ref_valid = 2'b11;
    logic       clk_out, active_src, no_valid;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always #5 clk_ref_a = ~clk_ref_a;
    initial begin #3; forever #7 clk_ref_b = ~clk_ref_b; end

    refclk_switch #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .clk_ref_a(clk_ref_a), .clk_ref_b(clk_ref_b),
        .ctrl_cfg(ctrl_cfg), .man_sel(man_sel), .ref_valid(ref_valid),
        .clk_out(clk_out), .active_src(active_src), .no_valid(no_valid)
    );

    // edge counters and pulse-width monitor
    bit  mon_on = 1'b0;
    int  n_out = 0, n_a = 0, n_b = 0, n_pulse = 0;
    realtime t_rise = 0.0, t_fall = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;

    always @(posedge clk_ref_a) if (mon_on) n_a++;
    always @(posedge clk_ref_b) if (mon_on) n_b++;
    always @(posedge clk_out) if (mon_on) begin
        n_out++;
        if (t_fall > 0.0 && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
        t_rise = $realtime;
    end
    always @(negedge clk_out) if (mon_on) begin
        if (t_rise > 0.0) begin
            n_pulse++;
            if (($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
        end
        t_fall = $realtime;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] cfg);
        @(negedge clk);
        rst = 1'b1; ctrl_cfg = cfg; ref_valid = 2'b11;
        step(10);
        check("R1 reset active_src", int'(active_src), int'(cfg[3]));
        check("R1 reset no_valid", int'(no_valid), 0);
        rst = 1'b0;
        step(1);
        check("R1 first cycle active_src", int'(active_src), int'(cfg[3]));
        check("R1 first cycle no_valid", int'(no_valid), 0);
    endtask

    task automatic check_follow(input logic idx, input string tag);
        int o0, a0, b0, d;
        step(30);
        o0 = n_out; a0 = n_a; b0 = n_b;
        step(50);
        d = idx ? (n_b - b0) : (n_a - a0);
        checks++;
        if ((n_out - o0) > d + 1 || (n_out - o0) < d - 1) begin
            errors++;
            $display("FAIL %s: actual %0d edges expected %0d", tag, n_out - o0, d);
        end
    endtask

    // {cfg[3:0], man_sel, ref_valid[1:0], exp_sel, exp_nv}
    localparam logic [8:0] VEC [12] = '{
        {4'b0000, 1'b1, 2'b11, 1'b1, 1'b0},
        {4'b0001, 1'b0, 2'b10, 1'b0, 1'b0},
        {4'b0001, 1'b1, 2'b00, 1'b1, 1'b0},
        {4'b0010, 1'b1, 2'b11, 1'b1, 1'b0},
        {4'b0010, 1'b0, 2'b01, 1'b0, 1'b0},
        {4'b0010, 1'b0, 2'b10, 1'b1, 1'b0},
        {4'b0010, 1'b0, 2'b11, 1'b1, 1'b0},
        {4'b0010, 1'b0, 2'b00, 1'b1, 1'b1},
        {4'b0010, 1'b0, 2'b01, 1'b0, 1'b0},
        {4'b1010, 1'b0, 2'b11, 1'b0, 1'b0},
        {4'b1110, 1'b0, 2'b11, 1'b0, 1'b0},
        {4'b1110, 1'b0, 2'b10, 1'b1, 1'b0}
    };

    function automatic string row_tag(input int i);
        if (i < 3)  return "R2 manual row";
        if (i == 7) return "R6 both invalid row";
        if (i == 8) return "R6 flag clears row";
        if (i >= 10) return "R7 reserved bit row";
        return "R4 holding failover row";
    endfunction

    initial begin
        do_reset(4'b0011);
        mon_on = 1'b1;
        check_follow(1'b0, "R9 clk_out follows a after reset");

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ctrl_cfg  = VEC[i][8:5];
            man_sel   = VEC[i][4];
            ref_valid = VEC[i][3:2];
            step(1);
            check($sformatf("%s %0d active_src", row_tag(i), i), int'(active_src), int'(VEC[i][1]));
            check($sformatf("%s %0d no_valid", row_tag(i), i), int'(no_valid), int'(VEC[i][0]));
        end
        check_follow(1'b1, "R9 clk_out follows b after failover");

        // reverting mode, primary a
        do_reset(4'b0011);
        ref_valid = 2'b10;
        step(1);
        check("R5 failover to backup", int'(active_src), 1);
        ref_valid = 2'b11;
        step(10);
        ref_valid = 2'b10;
        step(1);
        check("R5 interrupted count keeps backup", int'(active_src), 1);
        ref_valid = 2'b11;
        step(HOLD - 1);
        check("R5 no early return", int'(active_src), 1);
        step(1);
        check("R5 return to primary a", int'(active_src), 0);

        // priority bit moves the primary to b
        ctrl_cfg = 4'b1011;
        step(HOLD - 1);
        check("R3 still on a before count", int'(active_src), 0);
        step(1);
        check("R3 return to primary b", int'(active_src), 1);
        check_follow(1'b1, "R9 clk_out follows b after return");

        // reserved bit in reverting mode
        ctrl_cfg = 4'b0111;
        step(HOLD - 1);
        check("R7 reserved bit count unchanged", int'(active_src), 1);
        step(1);
        check("R7 reserved bit return to a", int'(active_src), 0);

        // both invalid in reverting mode
        ref_valid = 2'b00;
        step(1);
        check("R6 revert both invalid hold", int'(active_src), 0);
        check("R6 revert both invalid flag", int'(no_valid), 1);

        // reset with priority b
        do_reset(4'b1011);
        check_follow(1'b1, "R9 clk_out follows b after reset");

        ctrl_cfg = 4'b0000; man_sel = 1'b0;
        step(1);
        check("R2 manual back to a", int'(active_src), 0);
        check_follow(1'b0, "R9 clk_out follows a in manual");

        check("R8 pulses observed", int'(n_pulse > 100), 1);
        check("R8 min high phase ps", int'(min_hi * 1000.0 + 0.5) >= 5000 ? 1 : 0, 1);
        check("R8 min low phase ps", int'(min_lo * 1000.0 + 0.5) >= 5000 ? 1 : 0, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule